// File: doc/BRIEF.md
# Relocating Paged Memory Mapper

This block turns a 16-bit CPU logical address into a physical address for a large DRAM. The logical space is split into eight 8 KB windows. Each window has a small page register that user code writes with a byte. The mapper keeps that byte exactly as written, so software can read it back. It also adds a supervisor-owned base page to the byte and keeps the result as a 13-bit physical page, next to three mode bits.

The base page fences a user context into its own 2 MB slice of physical memory. User code can name at most 256 pages, and every one of them lands inside that slice. Only the supervisor can change the base page or the mode bits. When the base page changes, every window is relocated again from its stored byte in the same clock.

One mode bit sends a window to a separate expansion bus instead of DRAM. For such a window the upper physical lines stay low, so the expansion bus sees only a plain 64 KB space. The other two mode bits are passed out as attributes of the window.

Top module: `pmap_top`

## Requirements
- R1: After reset the base page is 0, every mode field is 0, and window i (i = 0..7) reads back i and maps to physical page i.
- R2: A user write of byte V to window s is returned unchanged on `usr_rdata` when `usr_rsel` = s, starting one cycle after the write.
- R3: One cycle after a user write of V to window s, accesses through window s use physical page (V + base) modulo 8192 in `phys_addr[25:13]`.
- R4: Logical bits [15:13] pick the window, and logical bits [12:0] appear unchanged on `phys_addr[12:0]` for DRAM windows.
- R5: A supervisor base write takes effect for all windows one cycle later. Each window is recomputed from its stored byte, and no stored byte changes.
- R6: When a user write and a base write occur in the same cycle, the written window uses both the new byte and the new base.
- R7: When mode bit 0 of the selected window is 1, `to_ext` is 1 and `phys_addr` equals the logical address with bits [25:16] forced to 0. When mode bit 0 is 0, `to_ext` is 0.
- R8: `page_attr` shows mode bits [2:1] of the selected window. Mode fields change only through a supervisor mode write, one cycle after it, and only for the addressed window.
- R9: User page writes and base writes leave all mode fields unchanged.
- R10: Page relocation wraps modulo 8192; for example, byte 255 with base 8190 gives page 253.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_we | input | 1 | User page-register write strobe |
| usr_sel | input | 3 | Window written by the user |
| usr_wdata | input | 8 | Page byte written by the user |
| usr_rsel | input | 3 | Window whose stored byte is read back |
| usr_rdata | output | 8 | Stored byte of window `usr_rsel` |
| sup_base_we | input | 1 | Supervisor base-page write strobe |
| sup_base | input | 13 | New base page |
| sup_mode_we | input | 1 | Supervisor mode write strobe |
| sup_mode_sel | input | 3 | Window whose mode field is written |
| sup_mode | input | 3 | New mode field (bit 0 = expansion bus, bits 2:1 = attributes) |
| cpu_laddr | input | 16 | CPU logical address |
| phys_addr | output | 26 | Translated physical address |
| to_ext | output | 1 | Access goes to the expansion bus |
| page_attr | output | 2 | Attribute bits of the selected window |

## Verification
The bench targets base-page wraparound. A mapper that keeps a carry beyond 13 bits, or that truncates the byte, would point a context outside its slice. It also targets a base change with many windows already written; a design that recomputed only the last-written window would leave the others at stale pages. It drives a user write and a base write in the same cycle, which catches a design that mixes the old base with the new byte. Finally, it checks that expansion windows keep the upper lines at zero and that later user writes leave the mode bits alone. A design that leaked the page number onto the expansion bus, or cleared the mode on a page write, would fail these checks.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
    // position of the target-select bit inside a mode field
    localparam int unsigned MODE_EXT_BIT = 0;

    typedef enum logic {
        TGT_DRAM = 1'b0,
        TGT_EXP  = 1'b1
    } target_e;
endpackage

// File: rtl/pmap_bank_file.sv
module pmap_bank_file #(
    parameter int BANK_W  = 3,
    parameter int UPAGE_W = 8,
    parameter int PPAGE_W = 13,
    parameter int MODE_W  = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  usr_we,
    input  logic [BANK_W-1:0]                     usr_sel,
    input  logic [UPAGE_W-1:0]                    usr_wdata,
    input  logic [BANK_W-1:0]                     usr_rsel,
    output logic [UPAGE_W-1:0]                    usr_rdata,
    input  logic                                  sup_base_we,
    input  logic [PPAGE_W-1:0]                    sup_base,
    input  logic                                  sup_mode_we,
    input  logic [BANK_W-1:0]                     sup_mode_sel,
    input  logic [MODE_W-1:0]                     sup_mode,
    output logic [(1<<BANK_W)-1:0][PPAGE_W-1:0]   bank_page,
    output logic [(1<<BANK_W)-1:0][MODE_W-1:0]    bank_mode
);
    localparam int NBANK = 1 << BANK_W;

    typedef struct packed {
        logic [NBANK-1:0][UPAGE_W-1:0] shadow;
        logic [NBANK-1:0][PPAGE_W-1:0] page;
        logic [NBANK-1:0][MODE_W-1:0]  mode;
        logic [PPAGE_W-1:0]            base;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (usr_we)      st_d.shadow[usr_sel]    = usr_wdata;
        if (sup_base_we) st_d.base               = sup_base;
        if (sup_mode_we) st_d.mode[sup_mode_sel] = sup_mode;
        for (int i = 0; i < NBANK; i++) begin
            if (sup_base_we || (usr_we && usr_sel == BANK_W'(i))) begin
                st_d.page[i] = PPAGE_W'(st_d.shadow[i]) + st_d.base;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base <= '0;
            for (int i = 0; i < NBANK; i++) begin
                st_q.shadow[i] <= UPAGE_W'(i);
                st_q.page[i]   <= PPAGE_W'(i);
                st_q.mode[i]   <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign usr_rdata = st_q.shadow[usr_rsel];
    assign bank_page = st_q.page;
    assign bank_mode = st_q.mode;

    // R2
    shadow_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_we |=> st_q.shadow[$past(usr_sel)] == $past(usr_wdata));

    // R3
    page_reloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_we && !sup_base_we) |=>
            bank_page[$past(usr_sel)] == PPAGE_W'($past(usr_wdata)) + st_q.base);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_mode_we |=> $stable(bank_mode));

    // R5
    for (genvar g = 0; g < NBANK; g++) begin : g_base_chk
        base_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sup_base_we |=> bank_page[g] == PPAGE_W'(st_q.shadow[g]) + st_q.base);
    end
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
    import pmap_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int OFF_W   = 13,
    parameter int PPAGE_W = 13,
    parameter int MODE_W  = 3
) (
    input  logic [LADDR_W-1:0]                            laddr,
    input  logic [(1<<(LADDR_W-OFF_W))-1:0][PPAGE_W-1:0]  bank_page,
    input  logic [(1<<(LADDR_W-OFF_W))-1:0][MODE_W-1:0]   bank_mode,
    output logic [PPAGE_W+OFF_W-1:0]                      phys_addr,
    output logic                                          to_ext,
    output logic [MODE_W-2:0]                             page_attr
);
    localparam int BANK_W  = LADDR_W - OFF_W;
    localparam int PADDR_W = PPAGE_W + OFF_W;

    logic [BANK_W-1:0] bank;
    logic [MODE_W-1:0] mode;
    target_e           tgt;

    always_comb begin
        bank      = laddr[LADDR_W-1:OFF_W];
        mode      = bank_mode[bank];
        tgt       = target_e'(mode[MODE_EXT_BIT]);
        page_attr = mode[MODE_W-1:1];
        to_ext    = (tgt == TGT_EXP);
        if (tgt == TGT_EXP) begin
            phys_addr = PADDR_W'(laddr);
        end else begin
            phys_addr = {bank_page[bank], laddr[OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/pmap_top.sv
module pmap_top #(
    parameter int LADDR_W = 16,
    parameter int OFF_W   = 13,
    parameter int UPAGE_W = 8,
    parameter int PPAGE_W = 13,
    parameter int MODE_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       usr_we,
    input  logic [LADDR_W-OFF_W-1:0]   usr_sel,
    input  logic [UPAGE_W-1:0]         usr_wdata,
    input  logic [LADDR_W-OFF_W-1:0]   usr_rsel,
    output logic [UPAGE_W-1:0]         usr_rdata,
    input  logic                       sup_base_we,
    input  logic [PPAGE_W-1:0]         sup_base,
    input  logic                       sup_mode_we,
    input  logic [LADDR_W-OFF_W-1:0]   sup_mode_sel,
    input  logic [MODE_W-1:0]          sup_mode,
    input  logic [LADDR_W-1:0]         cpu_laddr,
    output logic [PPAGE_W+OFF_W-1:0]   phys_addr,
    output logic                       to_ext,
    output logic [MODE_W-2:0]          page_attr
);
    localparam int BANK_W  = LADDR_W - OFF_W;
    localparam int NBANK   = 1 << BANK_W;
    localparam int PADDR_W = PPAGE_W + OFF_W;

    logic [NBANK-1:0][PPAGE_W-1:0] bank_page;
    logic [NBANK-1:0][MODE_W-1:0]  bank_mode;

    pmap_bank_file #(
        .BANK_W (BANK_W),
        .UPAGE_W(UPAGE_W),
        .PPAGE_W(PPAGE_W),
        .MODE_W (MODE_W)
    ) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .usr_we      (usr_we),
        .usr_sel     (usr_sel),
        .usr_wdata   (usr_wdata),
        .usr_rsel    (usr_rsel),
        .usr_rdata   (usr_rdata),
        .sup_base_we (sup_base_we),
        .sup_base    (sup_base),
        .sup_mode_we (sup_mode_we),
        .sup_mode_sel(sup_mode_sel),
        .sup_mode    (sup_mode),
        .bank_page   (bank_page),
        .bank_mode   (bank_mode)
    );

    pmap_xlate #(
        .LADDR_W(LADDR_W),
        .OFF_W  (OFF_W),
        .PPAGE_W(PPAGE_W),
        .MODE_W (MODE_W)
    ) u_xlate (
        .laddr    (cpu_laddr),
        .bank_page(bank_page),
        .bank_mode(bank_mode),
        .phys_addr(phys_addr),
        .to_ext   (to_ext),
        .page_attr(page_attr)
    );

    // R7
    ext_upper_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_ext |-> phys_addr[PADDR_W-1:LADDR_W] == '0);

    // R8
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_mode_we && cpu_laddr[LADDR_W-1:OFF_W] == sup_mode_sel) ##1
        (cpu_laddr[LADDR_W-1:OFF_W] == $past(sup_mode_sel))
            |-> page_attr == $past(sup_mode[MODE_W-1:1]));
endmodule

// File: tb/pmap_top_tb.sv
module pmap_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usr_we = 1'b0;
    logic [2:0]  usr_sel = '0;
    logic [7:0]  usr_wdata = '0;
    logic [2:0]  usr_rsel = '0;
    logic [7:0]  usr_rdata;
    logic        sup_base_we = 1'b0;
    logic [12:0] sup_base = '0;
    logic        sup_mode_we = 1'b0;
    logic [2:0]  sup_mode_sel = '0;
    logic [2:0]  sup_mode = '0;
    logic [15:0] cpu_laddr = '0;
    logic [25:0] phys_addr;
    logic        to_ext;
    logic [1:0]  page_attr;

    always #10 clk = ~clk;

    pmap_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .usr_we(usr_we), .usr_sel(usr_sel), .usr_wdata(usr_wdata),
        .usr_rsel(usr_rsel), .usr_rdata(usr_rdata),
        .sup_base_we(sup_base_we), .sup_base(sup_base),
        .sup_mode_we(sup_mode_we), .sup_mode_sel(sup_mode_sel), .sup_mode(sup_mode),
        .cpu_laddr(cpu_laddr), .phys_addr(phys_addr), .to_ext(to_ext), .page_attr(page_attr)
    );

    typedef struct {
        string       req;
        bit          is_rd;
        logic [25:0] phys;
        logic        ext;
        logic [1:0]  attr;
        logic [7:0]  rd;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;

    // reference model
    logic [7:0]  m_shadow [8];
    logic [2:0]  m_mode [8];
    logic [12:0] m_base;

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.is_rd) begin
                if (usr_rdata !== e.rd) begin
                    errors++;
                    $display("FAIL %s readback: got %0d expected %0d", e.req, usr_rdata, e.rd);
                end
            end else if (phys_addr !== e.phys || to_ext !== e.ext || page_attr !== e.attr) begin
                errors++;
                $display("FAIL %s xlate: got phys=%h ext=%b attr=%b expected phys=%h ext=%b attr=%b",
                         e.req, phys_addr, to_ext, page_attr, e.phys, e.ext, e.attr);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic usr_wr(input logic [2:0] s, input logic [7:0] v);
        usr_we = 1'b1; usr_sel = s; usr_wdata = v;
        step();
        usr_we = 1'b0;
        m_shadow[s] = v;
    endtask

    task automatic base_wr(input logic [12:0] b);
        sup_base_we = 1'b1; sup_base = b;
        step();
        sup_base_we = 1'b0;
        m_base = b;
    endtask

    task automatic both_wr(input logic [2:0] s, input logic [7:0] v, input logic [12:0] b);
        usr_we = 1'b1; usr_sel = s; usr_wdata = v;
        sup_base_we = 1'b1; sup_base = b;
        step();
        usr_we = 1'b0; sup_base_we = 1'b0;
        m_shadow[s] = v; m_base = b;
    endtask

    task automatic mode_wr(input logic [2:0] s, input logic [2:0] m);
        sup_mode_we = 1'b1; sup_mode_sel = s; sup_mode = m;
        step();
        sup_mode_we = 1'b0;
        m_mode[s] = m;
    endtask

    task automatic chk_x(input logic [15:0] la, input string req);
        exp_t e;
        logic [2:0]  bk;
        logic [12:0] pg;
        bk = la[15:13];
        pg = m_base + {5'b0, m_shadow[bk]};
        e.req = req; e.is_rd = 1'b0; e.rd = '0;
        e.ext = m_mode[bk][0];
        e.attr = m_mode[bk][2:1];
        e.phys = e.ext ? {10'b0, la} : {pg, la[12:0]};
        cpu_laddr = la;
        sb.push_back(e);
        step();
    endtask

    task automatic chk_rd(input logic [2:0] s, input string req);
        exp_t e;
        e.req = req; e.is_rd = 1'b1; e.rd = m_shadow[s];
        e.phys = '0; e.ext = 1'b0; e.attr = '0;
        usr_rsel = s;
        sb.push_back(e);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_shadow[i] = 8'(i);
            m_mode[i] = '0;
        end
        m_base = '0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        step();

        // R1: reset identity map and readback
        for (int i = 0; i < 8; i++) chk_rd(3'(i), "R1");
        for (int i = 0; i < 8; i++) chk_x({3'(i), 13'h0ABC}, "R1");

        // R2 / R3 / R4: user writes relocate with base 0
        usr_wr(3'd2, 8'hA5);
        chk_rd(3'd2, "R2");
        chk_x(16'h5FFF, "R3");
        chk_x(16'h4000, "R4");
        usr_wr(3'd7, 8'hFF);
        chk_x(16'hE123, "R4");
        chk_rd(3'd7, "R2");

        // R5: base change recomputes every window, shadows unchanged
        usr_wr(3'd0, 8'h10);
        usr_wr(3'd5, 8'h33);
        base_wr(13'h0100);
        for (int i = 0; i < 8; i++) chk_x({3'(i), 13'h1234}, "R5");
        for (int i = 0; i < 8; i++) chk_rd(3'(i), "R5");

        // R10: wraparound
        base_wr(13'd8190);
        chk_x(16'hE000, "R10");
        chk_x(16'h0001, "R10");

        // R6: simultaneous user and base write
        both_wr(3'd3, 8'h40, 13'h0800);
        chk_x(16'h6ABC, "R6");
        chk_x(16'hA000, "R6");
        chk_rd(3'd3, "R6");

        // R7 / R8: expansion bus and attributes
        mode_wr(3'd4, 3'b101);
        chk_x(16'h9F0E, "R7");
        chk_x(16'h8000, "R8");
        mode_wr(3'd1, 3'b110);
        chk_x(16'h2345, "R8");
        chk_x(16'h9F0E, "R8");

        // R9: page and base writes keep mode fields
        usr_wr(3'd4, 8'h77);
        base_wr(13'h1F00);
        chk_x(16'h8765, "R9");
        chk_x(16'h3333, "R9");
        chk_rd(3'd4, "R9");

        // R7: clearing bit 0 returns the window to DRAM
        mode_wr(3'd4, 3'b000);
        chk_x(16'h8765, "R7");

        while (sb.size() > 0) step();
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule